// File: doc/BRIEF.md
# Quad-Burst Split-Port ECC SRAM

This block models a synchronous SRAM with a write port and a read port. Every access is a burst of four beats. A write command comes with a word address and the first data beat in the same cycle. The next three beats follow on consecutive cycles. The write path packs the four beats into one wide word, adds extended Hamming check bits, and stores the whole codeword in a single array write. A read command fetches one codeword, corrects any single-bit error, and sends the word back as four consecutive beats on a separate output bus. Two status flags accompany those beats.

The model runs on a single beat-rate clock, and two beats make one command period. The read latency is either two or three command periods, which is four or six clocks from the read command to the first beat. It is chosen by an input that is captured only while reset is held. Reads and writes may be issued in the same cycle, and a read always sees every write issued in the same cycle or earlier, even one whose beats are still arriving. An injection input flips a single stored codeword bit so that the correction logic can be exercised from outside.

Top module: `sram_b4_ecc`

## Requirements
- R1: While reset is asserted and after its release, `rvalid_o`, `corr_o` and `uncorr_o` stay low until a read produces data.
- R2: The write beat sampled with `wr_i` is beat 0, and the following three cycles carry beats 1 to 3. Beat k occupies bits [k*BEAT_W +: BEAT_W] of the stored word, and a read returns the beats of that word in order 0 to 3.
- R3: `lat3_i` is captured only while `rst_ni` is low. When it is 0, the first beat appears 4 clocks after the cycle that carries `rd_i`; when it is 1, it appears 6 clocks after. Changing `lat3_i` after reset release does not change the latency.
- R4: `rvalid_o` is high for exactly four consecutive clocks per read. Reads issued 4 clocks apart give an unbroken beat stream.
- R5: A read and a write issued in the same cycle to different addresses both complete correctly.
- R6: A read returns the data of every write to its address issued in the same cycle or earlier, including a write whose beats are still being collected. A write issued after the read does not affect it.
- R7: The codeword is laid out with bit 0 as overall parity, bits at indices 1, 2, 4, 8, 16, 32 and 64 as check bits, and the data bits in ascending order at the remaining indices up to 79. Flipping any single codeword bit through `inj_i` leaves the read data correct, and `corr_o` is high with its four beats.
- R8: With two flipped bits in one stored codeword, the read raises `uncorr_o` and keeps `corr_o` low. A clean word reads with both flags low. Rewriting the address clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lat3_i | input | 1 | Latency select captured during reset: 0 = 4 clocks, 1 = 6 clocks |
| wr_i | input | 1 | Write command, first beat valid in the same cycle |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wdata_i | input | BEAT_W | Write data beat |
| rd_i | input | 1 | Read command |
| rd_addr_i | input | ADDR_W | Word address of the read |
| inj_i | input | 1 | Flip one stored codeword bit at the clock edge |
| inj_addr_i | input | ADDR_W | Word address to corrupt |
| inj_bit_i | input | BIT_W | Codeword bit index to flip |
| rdata_o | output | BEAT_W | Read data beat |
| rvalid_o | output | 1 | Read beat valid |
| corr_o | output | 1 | A single-bit error was corrected in this word |
| uncorr_o | output | 1 | A double-bit error was detected in this word |

## Verification
The assertions rely on the following conditions on the inputs:
- Read commands are at least four clocks apart, and so are write commands.
- `lat3_i` is steady in the clock before reset is released.
- An injection never targets the address whose write is being committed in that same cycle.

The bench meets these conditions by issuing each command through a four-clock burst task that places a read on one chosen beat of the burst. Read offsets are ordered across neighbouring bursts so that reads never come closer than four clocks. Injections are issued only between bursts, after the write commit.

// File: rtl/sram_b4_pkg.sv
package sram_b4_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN  = 2'd0,
    ECC_CORR   = 2'd1,
    ECC_UNCORR = 2'd2
  } ecc_stat_e;

  // smallest p with 2^p >= dw + p + 1
  function automatic int unsigned secded_chk_bits(int unsigned dw);
    int unsigned p;
    p = 1;
    while ((1 << p) < (dw + p + 1)) p++;
    return p;
  endfunction

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import sram_b4_pkg::*;
#(
  parameter int unsigned DW = 72,
  localparam int unsigned P  = secded_chk_bits(DW),
  localparam int unsigned N  = DW + P,
  localparam int unsigned CW = N + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] cw_o
);

  logic [CW-1:0] cw;

  always_comb begin
    int unsigned j;
    logic par;
    cw = '0;
    j  = 0;
    for (int unsigned pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        cw[pos] = data_i[j];
        j++;
      end
    end
    for (int unsigned k = 0; k < P; k++) begin
      par = 1'b0;
      for (int unsigned pos = 1; pos <= N; pos++) begin
        if (((pos >> k) & 1) == 1 && pos != (1 << k)) par ^= cw[pos];
      end
      cw[1 << k] = par;
    end
    cw[0] = ^cw[N:1];
  end

  assign cw_o = cw;

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import sram_b4_pkg::*;
#(
  parameter int unsigned DW = 72,
  localparam int unsigned P  = secded_chk_bits(DW),
  localparam int unsigned N  = DW + P,
  localparam int unsigned CW = N + 1
) (
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output ecc_stat_e     stat_o
);

  logic [P-1:0]  syn;
  logic          ovr;
  logic [CW-1:0] fix;

  always_comb begin
    syn = '0;
    for (int unsigned k = 0; k < P; k++) begin
      for (int unsigned pos = 1; pos <= N; pos++) begin
        if (((pos >> k) & 1) == 1) syn[k] ^= cw_i[pos];
      end
    end
    ovr = ^cw_i;
  end

  always_comb begin
    fix    = cw_i;
    stat_o = ECC_CLEAN;
    if (ovr) begin
      if (int'(syn) <= int'(N)) begin
        fix[syn] = ~fix[syn];
        stat_o   = ECC_CORR;
      end else begin
        stat_o = ECC_UNCORR;
      end
    end else if (syn != '0) begin
      stat_o = ECC_UNCORR;
    end
  end

  always_comb begin
    int unsigned j;
    data_o = '0;
    j      = 0;
    for (int unsigned pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        data_o[j] = fix[pos];
        j++;
      end
    end
  end

endmodule

// File: rtl/b4_wr_gather.sv
module b4_wr_gather #(
  parameter int unsigned BEAT_W = 18,
  parameter int unsigned BURST  = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned WORD_W = BEAT_W * BURST,
  localparam int unsigned CNT_W  = $clog2(BURST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BEAT_W-1:0] wdata_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [WORD_W-1:0] word_o
);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] beat_q [BURST-1];
  logic              take;
  logic [CNT_W-1:0]  slot;

  assign take = busy_q || wr_i;
  assign slot = busy_q ? cnt_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (wr_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        addr_q <= wr_addr_i;
      end
    end else if (cnt_q == CNT_W'(BURST - 1)) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < BURST - 1; g++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              beat_q[g] <= '0;
      else if (take && slot == CNT_W'(g))       beat_q[g] <= wdata_i;
    end
    assign word_o[g*BEAT_W +: BEAT_W] = beat_q[g];
  end
  // last beat goes straight to the array
  assign word_o[(BURST-1)*BEAT_W +: BEAT_W] = wdata_i;

  assign commit_o      = busy_q && (cnt_q == CNT_W'(BURST - 1));
  assign commit_addr_o = addr_q;

  // R2: a new write never lands inside a burst still being collected
  a_r2_wr_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !busy_q);

  // R2: commit comes BURST-1 clocks after the command
  a_r2_commit_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(commit_o) |-> $past(wr_i, BURST - 1));

endmodule

// File: rtl/b4_rd_serial.sv
module b4_rd_serial #(
  parameter int unsigned BEAT_W = 18,
  parameter int unsigned BURST  = 4,
  localparam int unsigned WORD_W = BEAT_W * BURST,
  localparam int unsigned REM_W  = $clog2(BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              corr_i,
  input  logic              uncorr_i,
  output logic [BEAT_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              corr_o,
  output logic              uncorr_o
);

  logic [WORD_W-1:0] sh_q;
  logic [REM_W-1:0]  rem_q;
  logic              cf_q, uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
      cf_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      rem_q <= REM_W'(BURST);
      cf_q  <= corr_i;
      uf_q  <= uncorr_i;
    end else if (rem_q != '0) begin
      sh_q  <= sh_q >> BEAT_W;
      rem_q <= rem_q - REM_W'(1);
      if (rem_q == REM_W'(1)) begin
        cf_q <= 1'b0;
        uf_q <= 1'b0;
      end
    end
  end

  assign rdata_o  = sh_q[BEAT_W-1:0];
  assign rvalid_o = (rem_q != '0);
  assign corr_o   = cf_q;
  assign uncorr_o = uf_q;

  // R8: the two flags are never raised together
  a_r8_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o));

  // R7: flags only travel with beats
  a_r7_flags_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (!corr_o && !uncorr_o));

endmodule

// File: rtl/sram_b4_ecc.sv
module sram_b4_ecc
  import sram_b4_pkg::*;
#(
  parameter int unsigned BEAT_W   = 18,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned BURST    = 4,
  parameter int unsigned LAT_LO   = 2,
  parameter int unsigned LAT_HI   = 3,
  parameter int unsigned BEATS_CMD = 2,
  localparam int unsigned WORD_W  = BEAT_W * BURST,
  localparam int unsigned CHK_W   = secded_chk_bits(WORD_W),
  localparam int unsigned CW_W    = WORD_W + CHK_W + 1,
  localparam int unsigned BIT_W   = $clog2(CW_W),
  localparam int unsigned DEPTH   = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat3_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BEAT_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              inj_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [BIT_W-1:0]  inj_bit_i,
  output logic [BEAT_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              corr_o,
  output logic              uncorr_o
);

  // fetch when the last write beat of a same-cycle write commits
  localparam int unsigned FETCH  = BURST - 1;
  localparam int unsigned LD_LO  = LAT_LO * BEATS_CMD - 1;
  localparam int unsigned LD_HI  = LAT_HI * BEATS_CMD - 1;
  localparam int unsigned PIPE   = (LD_HI > FETCH) ? LD_HI : FETCH;

  // ---------------- latency select ----------------
  logic lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= lat3_i;
  end

  // ---------------- write side ----------------
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] wr_word;
  logic [CW_W-1:0]   wr_cw;

  b4_wr_gather #(.BEAT_W(BEAT_W), .BURST(BURST), .ADDR_W(ADDR_W)) u_gather (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .wr_addr_i     (wr_addr_i),
    .wdata_i       (wdata_i),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .word_o        (wr_word)
  );

  secded_enc #(.DW(WORD_W)) u_enc (
    .data_i (wr_word),
    .cw_o   (wr_cw)
  );

  // ---------------- array ----------------
  logic [CW_W-1:0] mem_q [DEPTH];
  logic            inj_ok;

  assign inj_ok = inj_i && !(commit && inj_addr_i == commit_addr);

  always_ff @(posedge clk_i) begin
    if (commit) mem_q[commit_addr] <= wr_cw;
    if (inj_ok) mem_q[inj_addr_i]  <= mem_q[inj_addr_i] ^ (CW_W'(1) << inj_bit_i);
  end

  // ---------------- read command pipeline ----------------
  logic [PIPE:1]     tok_q;
  logic [ADDR_W-1:0] ra_q [FETCH+1];

  assign ra_q[0] = rd_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '0;
    else         tok_q <= {tok_q[PIPE-1:1], rd_i};
  end

  for (genvar s = 1; s <= FETCH; s++) begin : g_ra
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ra_q[s] <= '0;
      else         ra_q[s] <= ra_q[s-1];
    end
  end

  logic              fetch;
  logic [ADDR_W-1:0] f_addr;
  logic              hit;
  logic [CW_W-1:0]   dec_cw;
  logic [WORD_W-1:0] dec_data;
  ecc_stat_e         dec_stat;

  assign fetch  = tok_q[FETCH];
  assign f_addr = ra_q[FETCH];
  assign hit    = commit && (commit_addr == f_addr);
  assign dec_cw = hit ? wr_cw : mem_q[f_addr];

  secded_dec #(.DW(WORD_W)) u_dec (
    .cw_i   (dec_cw),
    .data_o (dec_data),
    .stat_o (dec_stat)
  );

  logic [WORD_W-1:0] hold_data_q;
  ecc_stat_e         hold_stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_data_q <= '0;
      hold_stat_q <= ECC_CLEAN;
    end else if (fetch) begin
      hold_data_q <= dec_data;
      hold_stat_q <= dec_stat;
    end
  end

  logic              load;
  logic              direct;
  logic [WORD_W-1:0] ld_data;
  ecc_stat_e         ld_stat;

  assign load    = lat_q ? tok_q[LD_HI] : tok_q[LD_LO];
  assign direct  = (lat_q ? LD_HI : LD_LO) == FETCH;
  assign ld_data = direct ? dec_data : hold_data_q;
  assign ld_stat = direct ? dec_stat : hold_stat_q;

  b4_rd_serial #(.BEAT_W(BEAT_W), .BURST(BURST)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   (ld_data),
    .corr_i   (ld_stat == ECC_CORR),
    .uncorr_i (ld_stat == ECC_UNCORR),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .corr_o   (corr_o),
    .uncorr_o (uncorr_o)
  );

  // R3: latency choice frozen outside reset
  a_r3_lat_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(lat_q));

  // R4: reads spaced at least one burst apart
  a_r4_rd_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !(|tok_q[FETCH:1]));

  // R4: a beat run never ends before BURST beats
  a_r4_run_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rvalid_o) |-> $past(rvalid_o, BURST));

  // R6: bypassed word is fresh from the encoder, so it decodes clean
  a_r6_bypass_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && hit) |-> (dec_stat == ECC_CLEAN));

endmodule

// File: tb/tb_sram_b4_ecc.sv
`timescale 1ns/1ps
module tb_sram_b4_ecc;

  localparam int BEAT_W = 18;
  localparam int ADDR_W = 6;
  localparam int BURST  = 4;
  localparam int WORD_W = BEAT_W * BURST;
  localparam int CW_W   = 80;
  localparam int BIT_W  = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lat3;
  logic              wr, rd, inj;
  logic [ADDR_W-1:0] wa, ra, ia;
  logic [BEAT_W-1:0] wd;
  logic [BIT_W-1:0]  ib;
  logic [BEAT_W-1:0] rdata;
  logic              rvalid, corr, uncorr;

  always #2 clk = ~clk;  // 250 MHz

  sram_b4_ecc dut (
    .clk_i(clk), .rst_ni(rst_n), .lat3_i(lat3),
    .wr_i(wr), .wr_addr_i(wa), .wdata_i(wd),
    .rd_i(rd), .rd_addr_i(ra),
    .inj_i(inj), .inj_addr_i(ia), .inj_bit_i(ib),
    .rdata_o(rdata), .rvalid_o(rvalid), .corr_o(corr), .uncorr_o(uncorr)
  );

  typedef struct {
    int              cyc;
    logic [BEAT_W-1:0] data;
    bit              chk_data;
    bit              corr;
    bit              uncorr;
    string           req;
  } beat_t;

  beat_t             exp_q[$];
  logic [WORD_W-1:0] model [int];
  int                inj_n [int];
  int                cyc = 0;
  int                lat_b = 4;
  int                checks = 0;
  int                errors = 0;
  bit                done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [WORD_W-1:0] mkw(int s);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < BURST; k++)
      w[k*BEAT_W +: BEAT_W] = BEAT_W'((s * 7919 + k * 104729) ^ 32'h2a5a5);
    return w;
  endfunction

  // monitor: pops expected beats as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected beat", 80'(rdata), 80'(0));
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(e.cyc == cyc, "R3", "beat cycle", 80'(cyc), 80'(e.cyc));
          if (e.chk_data) chk(rdata == e.data, e.req, "beat data", 80'(rdata), 80'(e.data));
          chk(corr == e.corr, e.uncorr ? "R8" : "R7", "corr flag", 80'(corr), 80'(e.corr));
          chk(uncorr == e.uncorr, "R8", "uncorr flag", 80'(uncorr), 80'(e.uncorr));
        end
      end else if (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
        beat_t e;
        e = exp_q.pop_front();
        chk(0, "R4", "missing beat", 80'(0), 80'(e.cyc));
      end
    end
  end

  task automatic push_read(logic [ADDR_W-1:0] a, string req);
    int n;
    n = inj_n.exists(int'(a)) ? inj_n[int'(a)] : 0;
    for (int k = 0; k < BURST; k++) begin
      beat_t e;
      e.cyc      = cyc + lat_b + k;
      e.data     = model[int'(a)][k*BEAT_W +: BEAT_W];
      e.chk_data = (n < 2);
      e.corr     = (n == 1);
      e.uncorr   = (n >= 2);
      e.req      = req;
      exp_q.push_back(e);
    end
  endtask

  // one four-clock burst slot; optional write, optional read at beat rd_off
  task automatic burst(bit do_wr, logic [ADDR_W-1:0] a_w, logic [WORD_W-1:0] w,
                       bit do_rd, logic [ADDR_W-1:0] a_r, int rd_off, string req);
    for (int k = 0; k < BURST; k++) begin
      wr = do_wr && (k == 0);
      wa = a_w;
      wd = do_wr ? w[k*BEAT_W +: BEAT_W] : '0;
      if (do_wr && k == 0) begin
        model[int'(a_w)] = w;
        inj_n[int'(a_w)] = 0;
      end
      rd = do_rd && (k == rd_off);
      ra = a_r;
      if (do_rd && k == rd_off) push_read(a_r, req);
      @(negedge clk);
    end
    wr = 0;
    rd = 0;
  endtask

  task automatic idle(int n);
    wr = 0; rd = 0; inj = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic inject(logic [ADDR_W-1:0] a, int b);
    inj = 1; ia = a; ib = BIT_W'(b);
    @(negedge clk);
    inj = 0;
    inj_n[int'(a)] = inj_n.exists(int'(a)) ? inj_n[int'(a)] + 1 : 1;
  endtask

  task automatic do_reset(bit l3);
    rst_n = 0; lat3 = l3; wr = 0; rd = 0; inj = 0;
    wa = '0; ra = '0; ia = '0; ib = '0; wd = '0;
    exp_q.delete();
    repeat (4) @(negedge clk);
    chk(!rvalid && !corr && !uncorr, "R1", "outputs in reset", 80'({rvalid, corr, uncorr}), 80'(0));
    rst_n = 1;
    lat_b = l3 ? 6 : 4;
    repeat (3) begin
      @(negedge clk);
      chk(!rvalid && !corr && !uncorr, "R1", "outputs after reset", 80'({rvalid, corr, uncorr}), 80'(0));
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "R4", "watchdog expired", 80'(cyc), 80'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; lat3 = 0; wr = 0; rd = 0; inj = 0;
    wa = '0; ra = '0; ia = '0; ib = '0; wd = '0;
    @(negedge clk);
    do_reset(1'b0);

    // R2 basic gather / serialize, R5 concurrent read+write
    burst(1, 6'd1, mkw(1), 0, '0, 0, "R2");
    burst(1, 6'd2, mkw(2), 0, '0, 0, "R2");
    burst(1, 6'd3, mkw(3), 1, 6'd1, 0, "R5");
    // R4 back-to-back reads
    burst(0, '0, '0, 1, 6'd2, 0, "R4");
    burst(0, '0, '0, 1, 6'd3, 0, "R4");
    burst(0, '0, '0, 1, 6'd1, 0, "R4");
    // R6 same-cycle and mid-burst coherence
    burst(1, 6'd4, mkw(40), 0, '0, 0, "R6");
    burst(1, 6'd4, mkw(41), 1, 6'd4, 0, "R6");
    burst(1, 6'd5, mkw(50), 0, '0, 0, "R6");
    burst(1, 6'd5, mkw(51), 1, 6'd5, 2, "R6");
    burst(1, 6'd6, mkw(60), 0, '0, 0, "R6");
    // R6 read one clock before a newer write: old data
    burst(0, '0, '0, 1, 6'd6, 3, "R6");
    burst(1, 6'd6, mkw(61), 0, '0, 0, "R6");
    idle(10);

    // R7 single data-bit error
    burst(1, 6'd8, mkw(80), 0, '0, 0, "R7");
    idle(1);
    inject(6'd8, 3);
    burst(0, '0, '0, 1, 6'd8, 0, "R7");
    burst(0, '0, '0, 1, 6'd8, 0, "R7");
    // R7 check-bit error
    burst(1, 6'd9, mkw(90), 0, '0, 0, "R7");
    idle(1);
    inject(6'd9, 4);
    burst(0, '0, '0, 1, 6'd9, 0, "R7");
    // R7 overall-parity and top data bit
    burst(1, 6'd11, mkw(110), 0, '0, 0, "R7");
    idle(1);
    inject(6'd11, 0);
    burst(1, 6'd12, mkw(120), 1, 6'd11, 0, "R7");
    idle(1);
    inject(6'd12, CW_W - 1);
    burst(0, '0, '0, 1, 6'd12, 0, "R7");
    // R8 double error, then rewrite clears it
    burst(1, 6'd10, mkw(100), 0, '0, 0, "R8");
    idle(1);
    inject(6'd10, 3);
    inject(6'd10, 40);
    burst(0, '0, '0, 1, 6'd10, 0, "R8");
    burst(1, 6'd10, mkw(101), 0, '0, 0, "R8");
    burst(0, '0, '0, 1, 6'd10, 0, "R8");
    idle(12);
    chk(exp_q.size() == 0, "R4", "queue drained", 80'(exp_q.size()), 80'(0));

    // R3 latency of six clocks, input change after reset ignored
    do_reset(1'b1);
    lat3 = 0;
    burst(0, '0, '0, 1, 6'd1, 0, "R3");
    burst(0, '0, '0, 1, 6'd2, 0, "R4");
    burst(0, '0, '0, 1, 6'd3, 0, "R4");
    burst(1, 6'd20, mkw(200), 0, '0, 0, "R6");
    burst(1, 6'd20, mkw(201), 1, 6'd20, 0, "R6");
    burst(1, 6'd21, mkw(210), 0, '0, 0, "R6");
    burst(0, '0, '0, 1, 6'd21, 3, "R6");
    burst(1, 6'd21, mkw(211), 0, '0, 0, "R6");
    burst(0, '0, '0, 1, 6'd21, 0, "R6");
    burst(1, 6'd22, mkw(220), 1, 6'd3, 1, "R5");
    burst(0, '0, '0, 1, 6'd22, 1, "R2");
    idle(14);
    chk(exp_q.size() == 0, "R4", "queue drained", 80'(exp_q.size()), 80'(0));
    chk(!rvalid && !corr && !uncorr, "R1", "idle outputs", 80'({rvalid, corr, uncorr}), 80'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

endmodule